// File: doc/BRIEF.md
# Low-Voltage Inhibit Status Controller

This block is the digital side of a supply-voltage monitor. Two analog comparators report whether the supply is under the falling trip level and whether it is over the rising trip level. There is one such pair for 5 V operation and one for 3 V operation. A configuration bit picks the pair in use. The selected pair is synchronised into the clock domain and drives a hysteretic low-voltage flag. The flag sets when the supply drops under the falling level, clears when the supply rises over the rising level, and keeps its value in the band between the two levels.

Software reads the flag through a single read-only byte register. When reset generation is enabled, the block also raises a reset request. That request holds for a minimum number of cycles and lasts for as long as the flag stays set. The monitor keeps working in wait mode with no special handling. In stop mode it runs only when a stop-enable configuration bit is set. When the monitor is not running, the flag is frozen and no request is made.

Top module: `lvi_status_ctrl`

## Requirements
- R1: While `rst_n` is low, `lvi_rst_req` is 0 and a read of the status address returns 0x00. The flag is cleared by reset.
- R2: While the monitor runs, a selected "below falling level" input held high sets the flag. The flag is visible in the register after the third rising clock edge, counting from the edge at which the input was first sampled.
- R3: While the monitor runs, a selected "above rising level" input with "below" low clears the flag with the same three-edge latency. With both inputs low, the flag keeps its value.
- R4: If both selected inputs are high together, the flag is set.
- R5: `cfg_sel_5v` = 1 selects the `cmp_*_5v` pair and 0 selects the `cmp_*_3v` pair. The unselected pair has no effect on the flag.
- R6: A read at address `REG_ADDR` returns the flag in bit 7 and 0 in bits 6..0. Any other address reads 0x00.
- R7: Writes to the status address, with any data, leave the flag unchanged.
- R8: With `cfg_mon_en` = 0, the flag holds its value whatever the comparators show, and `lvi_rst_req` is 0 in that same cycle.
- R9: With `mode_stop` = 1 and `cfg_stop_en` = 0, the flag holds and no request is made. With `cfg_stop_en` = 1, the monitor runs in stop mode exactly as in run mode.
- R10: While the monitor runs and `cfg_rst_en` = 1, `lvi_rst_req` is 1 whenever the flag is 1. After the flag clears, the request stays high for `STRETCH_CYC`-1 further cycles, so every request lasts at least `STRETCH_CYC` cycles.
- R11: With `cfg_rst_en` = 0, `lvi_rst_req` is 0 at once. The flag keeps working and stays readable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| cmp_fall_5v | input | 1 | 5 V comparator: supply below falling level (async) |
| cmp_rise_5v | input | 1 | 5 V comparator: supply above rising level (async) |
| cmp_fall_3v | input | 1 | 3 V comparator: supply below falling level (async) |
| cmp_rise_3v | input | 1 | 3 V comparator: supply above rising level (async) |
| cfg_sel_5v | input | 1 | 1 selects the 5 V pair, 0 the 3 V pair |
| cfg_mon_en | input | 1 | Monitor enable |
| cfg_rst_en | input | 1 | Reset request enable |
| cfg_stop_en | input | 1 | Keep monitor running in stop mode |
| mode_stop | input | 1 | System is in stop mode |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data (ignored) |
| bus_rdata | output | 8 | Read data |
| lvi_rst_req | output | 1 | Stretched reset request |

## Verification
Directed steps walk the supply through three regions on the 5 V pair: under the falling level, the band between the levels, and over the rising level. They also drive both inputs high at once. This separates set, hold, clear and the set-wins priority, and the samples taken at edge two and edge three pin the synchroniser latency. Other directed steps toggle the unselected pair, the monitor enable, stop mode with and without stop-enable, and the reset enable. These show which of those inputs freeze the flag and which only mask the request. A counted run of request cycles after the flag clears fixes the stretch length. Random phases then hold comparator regions for random lengths while reconfiguring, and mix in address misses and writes. This catches interactions that the directed order does not reach.

// File: rtl/lvi_pkg.sv
package lvi_pkg;

  typedef struct packed {
    logic below;  // supply under falling level
    logic above;  // supply over rising level
  } lvi_cmp_t;

  localparam int FLAG_BIT = 7;

  // Three-region rule; below has priority over above.
  function automatic logic f_next_flag(input logic cur, input lvi_cmp_t c);
    if (c.below)      return 1'b1;
    else if (c.above) return 1'b0;
    else              return cur;
  endfunction

  // Monitor runs unless disabled or stopped without stop permission.
  function automatic logic f_mon_active(input logic mon_en, input logic stop,
                                        input logic stop_en);
    return mon_en && !(stop && !stop_en);
  endfunction

  function automatic logic [7:0] f_status_byte(input logic flag);
    logic [7:0] b;
    b = 8'h00;
    b[FLAG_BIT] = flag;
    return b;
  endfunction

endpackage

// File: rtl/lvi_sync.sv
module lvi_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] stage1, stage2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= d_async;
      stage2 <= stage1;
    end
  end

  assign q_sync = stage2;
endmodule

// File: rtl/lvi_hyst.sv
module lvi_hyst
  import lvi_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     active,
  input  lvi_cmp_t cmp,
  output logic     flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag <= 1'b0;
    else if (active) flag <= f_next_flag(flag, cmp);
  end
endmodule

// File: rtl/lvi_rst_stretch.sv
module lvi_rst_stretch #(
  parameter int STRETCH_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic path_en,
  input  logic flag,
  output logic req
);
  localparam int CNT_W = $clog2(STRETCH_CYC + 1);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(STRETCH_CYC - 1);

  logic [CNT_W-1:0] tail_cnt;
  logic             tail_busy;

  assign tail_busy = (tail_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         tail_cnt <= '0;
    else if (!path_en)  tail_cnt <= '0;
    else if (flag)      tail_cnt <= LOAD_VAL;
    else if (tail_busy) tail_cnt <= tail_cnt - 1'b1;
  end

  assign req = path_en && (flag || tail_busy);
endmodule

// File: rtl/lvi_status_ctrl.sv
module lvi_status_ctrl
  import lvi_pkg::*;
#(
  parameter int          ADDR_W      = 16,
  parameter logic [15:0] REG_ADDR    = 16'h00C0,
  parameter int          STRETCH_CYC = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_fall_5v,
  input  logic              cmp_rise_5v,
  input  logic              cmp_fall_3v,
  input  logic              cmp_rise_3v,
  input  logic              cfg_sel_5v,
  input  logic              cfg_mon_en,
  input  logic              cfg_rst_en,
  input  logic              cfg_stop_en,
  input  logic              mode_stop,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              lvi_rst_req
);
  localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(REG_ADDR);

  lvi_cmp_t cmp_raw, cmp_s;
  logic     below_s, above_s;
  logic     mon_active, rst_path_en;
  logic     flag_q;
  logic     addr_hit, wr_hit;

  // Pair chosen before synchronising: configuration is quasi-static.
  assign cmp_raw = cfg_sel_5v ? '{below: cmp_fall_5v, above: cmp_rise_5v}
                              : '{below: cmp_fall_3v, above: cmp_rise_3v};

  lvi_sync #(.W(2)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (cmp_raw),
    .q_sync  (cmp_s)
  );

  assign below_s     = cmp_s.below;
  assign above_s     = cmp_s.above;
  assign mon_active  = f_mon_active(cfg_mon_en, mode_stop, cfg_stop_en);
  assign rst_path_en = mon_active && cfg_rst_en;

  lvi_hyst u_hyst (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (mon_active),
    .cmp    (cmp_s),
    .flag   (flag_q)
  );

  lvi_rst_stretch #(.STRETCH_CYC(STRETCH_CYC)) u_stretch (
    .clk     (clk),
    .rst_n   (rst_n),
    .path_en (rst_path_en),
    .flag    (flag_q),
    .req     (lvi_rst_req)
  );

  // Read-only register: writes are decoded only so that checks can see them.
  assign addr_hit  = (bus_addr == MY_ADDR);
  assign wr_hit    = addr_hit && bus_wr;
  assign bus_rdata = addr_hit ? f_status_byte(flag_q) : 8'h00;
endmodule

module lvi_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       flag,
  input logic       below_s,
  input logic       above_s,
  input logic       mon_active,
  input logic       rst_path_en,
  input logic       wr_hit,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic       req
);
  // R2
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_active && below_s) |=> flag);

  // R3
  flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_active && above_s && !below_s) |=> !flag);

  // R3
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!below_s && !above_s) |=> $stable(flag));

  // R8
  frozen_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mon_active |=> $stable(flag));

  // R6
  low_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[6:0] == 7'd0);

  // R7
  write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && (wdata[7] != flag) && !mon_active) |=> $stable(flag));

  // R10
  req_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> rst_path_en);

  // R10
  req_on_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_path_en && flag) |-> req);

  // R10
  req_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_path_en && $past(rst_path_en) && $fell(flag)) |-> req);
endmodule

bind lvi_status_ctrl lvi_status_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .flag        (flag_q),
  .below_s     (below_s),
  .above_s     (above_s),
  .mon_active  (mon_active),
  .rst_path_en (rst_path_en),
  .wr_hit      (wr_hit),
  .wdata       (bus_wdata),
  .rdata       (bus_rdata),
  .req         (lvi_rst_req)
);

// File: tb/test_lvi_status_ctrl.sv
module test_lvi_status_ctrl;
  localparam int          ADDR_W  = 16;
  localparam logic [15:0] REG_A   = 16'h00C0;
  localparam int          STRETCH = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic f5 = 0, r5 = 0, f3 = 0, r3 = 0;
  logic sel5 = 1, mon = 1, rsten = 1, stopen = 0, stop = 0;
  logic [ADDR_W-1:0] addr = REG_A;
  logic wr = 0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic req;

  int n_tests = 0, n_fail = 0, cyc_cnt = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  lvi_status_ctrl #(.ADDR_W(ADDR_W), .REG_ADDR(REG_A), .STRETCH_CYC(STRETCH))
  i_lvi_status_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cmp_fall_5v(f5), .cmp_rise_5v(r5), .cmp_fall_3v(f3), .cmp_rise_3v(r3),
    .cfg_sel_5v(sel5), .cfg_mon_en(mon), .cfg_rst_en(rsten),
    .cfg_stop_en(stopen), .mode_stop(stop),
    .bus_addr(addr), .bus_wr(wr), .bus_wdata(wdata),
    .bus_rdata(rdata), .lvi_rst_req(req)
  );

  // ---------------- reference model ----------------
  logic [1:0] m_s1, m_s2;  // {below, above}
  logic m_flag;
  int   m_since;

  function automatic bit runs(input bit en, input bit st, input bit st_en);
    if (!en) return 0;
    if (st && !st_en) return 0;
    return 1;
  endfunction

  function automatic bit exp_req();
    bit en;
    en = runs(mon, stop, stopen) && rsten;
    return en && (m_flag || (m_since < STRETCH - 1));
  endfunction

  function automatic logic [7:0] exp_rd();
    return (addr == REG_A) ? (m_flag ? 8'h80 : 8'h00) : 8'h00;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= 2'b00; m_s2 <= 2'b00; m_flag <= 1'b0; m_since <= STRETCH;
    end else begin
      m_s1 <= sel5 ? {f5, r5} : {f3, r3};
      m_s2 <= m_s1;
      if (runs(mon, stop, stopen)) begin
        if (m_s2[1])      m_flag <= 1'b1;
        else if (m_s2[0]) m_flag <= 1'b0;
      end
      if (!(runs(mon, stop, stopen) && rsten)) m_since <= STRETCH;
      else if (m_flag)                          m_since <= 0;
      else if (m_since < STRETCH)               m_since <= m_since + 1;
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 100000 && !done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc_cnt, 100000);
      finish_run();
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    int n;
    int hold5, hold3;
    void'($urandom(32'h1A5E_0C17));
    cyc(3);
    // R1 reset state
    chk(rdata == 8'h00, "R1 rdata in reset", rdata, 0);
    chk(req == 1'b0, "R1 req in reset", req, 0);
    rst_n = 1'b1;
    cyc(2);
    chk(rdata == 8'h00, "R1 rdata after reset", rdata, 0);

    // R2 set with three-edge latency
    f5 = 1;
    cyc(2);
    chk(rdata == 8'h00, "R2 flag before third edge", rdata, 0);
    cyc(1);
    chk(rdata == 8'h80, "R2 flag set", rdata, 8'h80);
    chk(req == 1'b1, "R10 req with flag", req, 1);

    // R3 hold between levels, R5 unselected pair ignored
    f5 = 0; r3 = 1;
    cyc(6);
    chk(rdata == 8'h80, "R3 hold in band / R5 3v pair ignored", rdata, 8'h80);

    // R3 clear, R10 stretch length
    r5 = 1;
    cyc(2);
    chk(rdata == 8'h80, "R3 flag before third edge", rdata, 8'h80);
    cyc(1);
    chk(rdata == 8'h00, "R3 flag cleared", rdata, 0);
    n = 0;
    while (req && n < 100) begin n++; cyc(1); end
    chk(n == STRETCH - 1, "R10 request tail length", n, STRETCH - 1);

    // R7 write ignored, R6 other address
    wr = 1; wdata = 8'hFF;
    cyc(1);
    wr = 0;
    cyc(2);
    chk(rdata == 8'h00, "R7 write has no effect", rdata, 0);
    addr = REG_A + 16'd1;
    #1 chk(rdata == 8'h00, "R6 other address reads zero", rdata, 0);
    addr = REG_A;

    // R4 both active
    f5 = 1; r5 = 1;
    cyc(3);
    chk(rdata == 8'h80, "R4 both inputs set flag", rdata, 8'h80);

    // R8 monitor disabled
    mon = 0; f5 = 0; r5 = 1;
    #1 chk(req == 1'b0, "R8 no request when disabled", req, 0);
    cyc(6);
    chk(rdata == 8'h80, "R8 flag holds when disabled", rdata, 8'h80);
    mon = 1;
    cyc(1);
    chk(rdata == 8'h00, "R8 flag resumes after enable", rdata, 0);
    cyc(20);

    // R9 stop mode
    stop = 1; stopen = 0; f5 = 1; r5 = 0;
    cyc(6);
    chk(rdata == 8'h00, "R9 flag frozen in stop", rdata, 0);
    chk(req == 1'b0, "R9 no request in stop", req, 0);
    stopen = 1;
    cyc(1);
    chk(rdata == 8'h80, "R9 flag sets with stop enable", rdata, 8'h80);
    chk(req == 1'b1, "R9 request in stop with enable", req, 1);

    // R11 reset generation disabled
    rsten = 0;
    #1 chk(req == 1'b0, "R11 request off", req, 0);
    chk(rdata == 8'h80, "R11 flag still readable", rdata, 8'h80);

    // R5 switch to 3v pair
    stop = 0; rsten = 1; sel5 = 0; f3 = 0; r3 = 1;
    cyc(3);
    chk(rdata == 8'h00, "R5 3v pair clears flag", rdata, 0);
    cyc(20);

    // random phase against the model (R2 R3 R4 R5 R6 R8 R9 R10 R11)
    hold5 = 0; hold3 = 0;
    for (int i = 0; i < 4000; i++) begin
      chk(rdata == exp_rd(), "R2/R3/R6 random rdata", rdata, exp_rd());
      chk(req == exp_req(), "R10/R11 random req", req, exp_req());
      if (i % 150 == 0) begin
        sel5   = 1'($urandom_range(0, 1));
        mon    = ($urandom_range(0, 7) != 0);
        rsten  = ($urandom_range(0, 3) != 0);
        stop   = ($urandom_range(0, 3) == 0);
        stopen = 1'($urandom_range(0, 1));
      end
      if (hold5 == 0) begin
        case ($urandom_range(0, 9))
          0, 1, 2: begin f5 = 1; r5 = 0; end
          3, 4, 5: begin f5 = 0; r5 = 1; end
          9:       begin f5 = 1; r5 = 1; end
          default: begin f5 = 0; r5 = 0; end
        endcase
        hold5 = $urandom_range(1, 30);
      end else hold5--;
      if (hold3 == 0) begin
        case ($urandom_range(0, 2))
          0:       begin f3 = 1; r3 = 0; end
          1:       begin f3 = 0; r3 = 1; end
          default: begin f3 = 0; r3 = 0; end
        endcase
        hold3 = $urandom_range(1, 30);
      end else hold3--;
      addr  = ($urandom_range(0, 3) != 0) ? REG_A : ADDR_W'($urandom);
      wr    = 1'($urandom_range(0, 1));
      wdata = 8'($urandom);
      #1;
      cyc(1);
    end

    done = 1;
    finish_run();
  end
endmodule